// File: doc/BRIEF.md
# Receive Lost-Frame Statistics Counter

This block tallies receive frames that a network controller had to drop, split by cause. One tally counts frames discarded because no host buffer was free to take them. The other counts frames lost when the receive FIFO overflowed. Each tally saturates at its maximum and raises a sticky flag once it has overflowed.

Both tallies and both flags are presented together as one 32-bit status word. Reading that word clears it. The controller feeds the block one single-cycle pulse per lost frame on either cause input. Software polls the word through a read strobe.

A read returns the word as it stands in that cycle. From the next cycle the block starts a fresh interval. A loss that coincides with the read is carried into the new interval, so no event is dropped between two reads.

Top module: `rx_loss_stat_ctr`

## Requirements
- R1: After reset the status word reads 0x00000000.
- R2: Each cycle with the no-buffer pulse high increments the 16-bit no-buffer count in bits 15:0 by one.
- R3: Each cycle with the FIFO-overflow pulse high increments the 11-bit FIFO-overflow count in bits 27:17 by one.
- R4: A no-buffer pulse arriving while the count is 0xFFFF leaves the count at 0xFFFF and sets the no-buffer overflow flag at bit 16.
- R5: A FIFO-overflow pulse arriving while the count is 0x7FF leaves the count at 0x7FF and sets the FIFO overflow flag at bit 28. The flag therefore means 0x800 or more events.
- R6: An overflow flag, once set, stays set while no read occurs, even with further pulses.
- R7: While the read strobe is high, the word shows the accumulated value. In the following cycle both counts and both flags are zero, provided no pulse came with the read.
- R8: A pulse present in the same cycle as the read gives a count of exactly one for its cause in the following cycle.
- R9: Bits 31:29 of the status word are always zero.
- R10: In a cycle with no pulse and no read, the status word keeps its value.
- R11: The two causes count independently. Pulses on both inputs in one cycle each increment their own field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nobuf_evt_i | input | 1 | One-cycle pulse: frame dropped because no host buffer was free |
| fifo_ovf_evt_i | input | 1 | One-cycle pulse: frame lost to receive FIFO overflow |
| rd_i | input | 1 | Read strobe; the word is returned this cycle and cleared for the next |
| stat_o | output | 32 | Packed status word: counts, overflow flags, zero upper bits |

## Verification
The assertions assume that the event inputs and the read strobe are sampled cleanly at each rising edge. A pulse held high for several cycles is taken as that many separate events, and the properties count it that way. The stimulus changes every input only on the falling edge and holds it for whole cycles. Long event bursts are modelled as back-to-back single-cycle pulses, so each high cycle maps to one expected increment.

// File: rtl/rx_loss_pkg.sv
package rx_loss_pkg;

    // Field widths of the two tallies
    localparam int unsigned NOBUF_W = 16;
    localparam int unsigned FOVF_W  = 11;
    localparam int unsigned WORD_W  = 32;

    // Derived bit positions inside the status word
    localparam int unsigned NOBUF_LSB = 0;
    localparam int unsigned NOBUF_FLG = NOBUF_LSB + NOBUF_W;
    localparam int unsigned FOVF_LSB  = NOBUF_FLG + 1;
    localparam int unsigned FOVF_FLG  = FOVF_LSB + FOVF_W;
    localparam int unsigned USED_W    = FOVF_FLG + 1;

    function automatic logic [NOBUF_W-1:0] get_nobuf_cnt(input logic [WORD_W-1:0] w);
        return w[NOBUF_LSB +: NOBUF_W];
    endfunction

    function automatic logic get_nobuf_flg(input logic [WORD_W-1:0] w);
        return w[NOBUF_FLG];
    endfunction

    function automatic logic [FOVF_W-1:0] get_fovf_cnt(input logic [WORD_W-1:0] w);
        return w[FOVF_LSB +: FOVF_W];
    endfunction

    function automatic logic get_fovf_flg(input logic [WORD_W-1:0] w);
        return w[FOVF_FLG];
    endfunction

endpackage

// File: rtl/rx_loss_sat_ctr.sv
module rx_loss_sat_ctr #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             inc_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);

    localparam logic [CNT_W-1:0] MAX_V = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE_V = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } ctr_t;

    ctr_t st_d, st_q;
    ctr_t base;

    always_comb begin
        // Start from the cleared state when a read closes the interval
        base = clr_i ? '0 : st_q;
        st_d = base;
        if (inc_i) begin
            if (base.cnt == MAX_V) begin
                st_d.ovf = 1'b1;
            end else begin
                st_d.cnt = base.cnt + ONE_V;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign ovf_o = st_q.ovf;

endmodule

// File: rtl/rx_loss_pack.sv
module rx_loss_pack
    import rx_loss_pkg::*;
(
    input  logic [NOBUF_W-1:0] nobuf_cnt_i,
    input  logic               nobuf_ovf_i,
    input  logic [FOVF_W-1:0]  fovf_cnt_i,
    input  logic               fovf_ovf_i,
    output logic [WORD_W-1:0]  word_o
);

    always_comb begin
        word_o = '0;
        word_o[NOBUF_LSB +: NOBUF_W] = nobuf_cnt_i;
        word_o[NOBUF_FLG]            = nobuf_ovf_i;
        word_o[FOVF_LSB +: FOVF_W]   = fovf_cnt_i;
        word_o[FOVF_FLG]             = fovf_ovf_i;
    end

endmodule

// File: rtl/rx_loss_stat_ctr.sv
module rx_loss_stat_ctr
    import rx_loss_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        nobuf_evt_i,
    input  logic        fifo_ovf_evt_i,
    input  logic        rd_i,
    output logic [31:0] stat_o
);

    logic [NOBUF_W-1:0] nobuf_cnt;
    logic               nobuf_ovf;
    logic [FOVF_W-1:0]  fovf_cnt;
    logic               fovf_ovf;

    rx_loss_sat_ctr #(.CNT_W(NOBUF_W)) nobuf_ctr_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .inc_i  (nobuf_evt_i),
        .clr_i  (rd_i),
        .cnt_o  (nobuf_cnt),
        .ovf_o  (nobuf_ovf)
    );

    rx_loss_sat_ctr #(.CNT_W(FOVF_W)) fovf_ctr_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .inc_i  (fifo_ovf_evt_i),
        .clr_i  (rd_i),
        .cnt_o  (fovf_cnt),
        .ovf_o  (fovf_ovf)
    );

    rx_loss_pack pack_i (
        .nobuf_cnt_i (nobuf_cnt),
        .nobuf_ovf_i (nobuf_ovf),
        .fovf_cnt_i  (fovf_cnt),
        .fovf_ovf_i  (fovf_ovf),
        .word_o      (stat_o)
    );

endmodule

// File: rtl/rx_loss_stat_chk.sv
module rx_loss_stat_chk
    import rx_loss_pkg::*;
(
    input logic        clk_i,
    input logic        rst_ni,
    input logic        nobuf_evt_i,
    input logic        fifo_ovf_evt_i,
    input logic        rd_i,
    input logic [31:0] stat_o
);

    localparam logic [NOBUF_W-1:0] NB_MAX = {NOBUF_W{1'b1}};
    localparam logic [FOVF_W-1:0]  FO_MAX = {FOVF_W{1'b1}};

    // R9
    top_bits_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat_o[31:USED_W] == '0);

    // R2
    nobuf_incr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (nobuf_evt_i && !rd_i && get_nobuf_cnt(stat_o) != NB_MAX) |=>
        get_nobuf_cnt(stat_o) == get_nobuf_cnt($past(stat_o)) + 1'b1);

    // R3
    fovf_incr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fifo_ovf_evt_i && !rd_i && get_fovf_cnt(stat_o) != FO_MAX) |=>
        get_fovf_cnt(stat_o) == get_fovf_cnt($past(stat_o)) + 1'b1);

    // R4
    nobuf_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (nobuf_evt_i && !rd_i && get_nobuf_cnt(stat_o) == NB_MAX) |=>
        (get_nobuf_cnt(stat_o) == NB_MAX && get_nobuf_flg(stat_o)));

    // R5
    fovf_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fifo_ovf_evt_i && !rd_i && get_fovf_cnt(stat_o) == FO_MAX) |=>
        (get_fovf_cnt(stat_o) == FO_MAX && get_fovf_flg(stat_o)));

    // R6
    flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rd_i && get_nobuf_flg(stat_o)) |=> get_nobuf_flg(stat_o));

    // R7
    read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && !nobuf_evt_i && !fifo_ovf_evt_i) |=> stat_o == '0);

    // R8
    read_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && nobuf_evt_i) |=>
        (get_nobuf_cnt(stat_o) == 1 && !get_nobuf_flg(stat_o)));

    // R10
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rd_i && !nobuf_evt_i && !fifo_ovf_evt_i) |=> $stable(stat_o));

endmodule

bind rx_loss_stat_ctr rx_loss_stat_chk chk_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .nobuf_evt_i    (nobuf_evt_i),
    .fifo_ovf_evt_i (fifo_ovf_evt_i),
    .rd_i           (rd_i),
    .stat_o         (stat_o)
);

// File: tb/rx_loss_stat_ctr_tb_top.sv
module rx_loss_stat_ctr_tb_top;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        nobuf_evt_i = 1'b0;
    logic        fifo_ovf_evt_i = 1'b0;
    logic        rd_i = 1'b0;
    logic [31:0] stat_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk_i = ~clk_i;   // 250 MHz

    rx_loss_stat_ctr dut_i (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .nobuf_evt_i    (nobuf_evt_i),
        .fifo_ovf_evt_i (fifo_ovf_evt_i),
        .rd_i           (rd_i),
        .stat_o         (stat_o)
    );

    // Expected word built from independent field values
    function automatic logic [31:0] mk(input int nb, input bit nbf, input int fo, input bit fof);
        logic [31:0] w;
        w = 32'h0;
        w[15:0]  = nb[15:0];
        w[16]    = nbf;
        w[27:17] = fo[10:0];
        w[28]    = fof;
        return w;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    // Hold inputs for n cycles, changing them on the falling edge
    task automatic drive(input bit nb, input bit fo, input bit rd, input int n);
        @(negedge clk_i);
        nobuf_evt_i = nb; fifo_ovf_evt_i = fo; rd_i = rd;
        repeat (n) @(negedge clk_i);
        nobuf_evt_i = 1'b0; fifo_ovf_evt_i = 1'b0; rd_i = 1'b0;
    endtask

    // Read: check the returned word, then the cleared word
    task automatic do_read(input string req, input logic [31:0] exp_ret);
        @(negedge clk_i);
        rd_i = 1'b1;
        #1 chk(req, stat_o, exp_ret);
        @(negedge clk_i);
        rd_i = 1'b0;
        chk("R7 clear", stat_o, 32'h0);
    endtask

    task automatic t_reset;
        #1 chk("R1 reset", stat_o, 32'h0);
        chk("R9 top bits", {29'h0, stat_o[31:29]}, 32'h0);
    endtask

    task automatic t_counts;
        drive(1, 0, 0, 5);
        chk("R2 nobuf count", stat_o, mk(5, 0, 0, 0));
        drive(0, 1, 0, 3);
        chk("R3 fifo count", stat_o, mk(5, 0, 3, 0));
        repeat (4) @(negedge clk_i);
        chk("R10 idle hold", stat_o, mk(5, 0, 3, 0));
        do_read("R7 read return", mk(5, 0, 3, 0));
    endtask

    task automatic t_both;
        drive(1, 1, 0, 7);
        chk("R11 both causes", stat_o, mk(7, 0, 7, 0));
        do_read("R7 read return both", mk(7, 0, 7, 0));
    endtask

    task automatic t_read_event;
        drive(1, 0, 0, 4);
        @(negedge clk_i);
        rd_i = 1'b1; nobuf_evt_i = 1'b1; fifo_ovf_evt_i = 1'b1;
        #1 chk("R8 read return", stat_o, mk(4, 0, 0, 0));
        @(negedge clk_i);
        rd_i = 1'b0; nobuf_evt_i = 1'b0; fifo_ovf_evt_i = 1'b0;
        chk("R8 carried event", stat_o, mk(1, 0, 1, 0));
        do_read("R8 read after carry", mk(1, 0, 1, 0));
    endtask

    task automatic t_nobuf_sat;
        drive(1, 0, 0, 65535);
        chk("R4 at max", stat_o, mk(65535, 0, 0, 0));
        drive(1, 0, 0, 1);
        chk("R4 saturate flag", stat_o, mk(65535, 1, 0, 0));
        drive(1, 1, 0, 3);
        chk("R6 sticky under pulses", stat_o, mk(65535, 1, 3, 0));
        chk("R9 top bits sat", {29'h0, stat_o[31:29]}, 32'h0);
        do_read("R4 read saturated", mk(65535, 1, 3, 0));
    endtask

    task automatic t_fovf_sat;
        drive(0, 1, 0, 2047);
        chk("R5 at max", stat_o, mk(0, 0, 2047, 0));
        drive(0, 1, 0, 2);
        chk("R5 saturate flag", stat_o, mk(0, 0, 2047, 1));
        repeat (3) @(negedge clk_i);
        chk("R6 sticky idle", stat_o, mk(0, 0, 2047, 1));
        @(negedge clk_i);
        rd_i = 1'b1; fifo_ovf_evt_i = 1'b1;
        #1 chk("R5 read return", stat_o, mk(0, 0, 2047, 1));
        @(negedge clk_i);
        rd_i = 1'b0; fifo_ovf_evt_i = 1'b0;
        chk("R8 flag cleared on carry", stat_o, mk(0, 0, 1, 0));
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        t_counts();
        t_both();
        t_read_event();
        t_nobuf_sat();
        t_fovf_sat();
        done = 1'b1;
    end

    initial begin : watchdog
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk_i);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule